// File: doc/BRIEF.md
# Self-Programming Flash Command Controller

This block holds the 8-bit control and status register that governs on-chip program memory self-programming. Software writes the register with the enable bit and one command bit: page write, page erase or lock/fuse read. That write opens a short window counted in clock cycles. A matching store-program strobe or load-program strobe inside the window launches the command. If no matching strobe arrives, the window expires and the command and enable bits clear themselves.

Page operations are passed to the flash engine as a request that is held until the engine acknowledges it. The CPU is halted for that whole time. The page number is taken from the upper bits of the Z-pointer when the strobe is accepted. A lock/fuse read gives a one-cycle select pulse, and Z-pointer bit 0 chooses between lock bits and fuse bits. The block also pulses a clear of the temporary page buffer, and it raises a ready interrupt when self-programming is idle.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and every output (requests, halt, buffer clear, select pulse, interrupt) is 0.
- R2: The register read value is {irq_en[7], 0[6], 0[5], sect_en[4], lock_rd[3], pg_wr[2], pg_er[1], sp_en[0]}. Bits 7 and 4 read back as last written. Bits 6 and 5 always read 0. Command bits 3..1 are stored only when bit 0 is written 1 in the same write, and otherwise they store 0.
- R3: A write that sets bit 0 and bit 2, with no other command bit, arms a 4-cycle window. A store strobe in any of the 4 cycles after the write raises write_req from the next cycle. page_addr then equals the Z-pointer bits above PAGE_LSB (default bits 15..6), sampled at the strobe.
- R4: A write that sets bit 0 and bit 1, with no other command bit, behaves as in R3 but raises erase_req.
- R5: A page request and halt_cpu stay high, with page_addr stable, until op_ack. They are low in the cycle after the acknowledge, and bits 2..0 then read 0.
- R6: If no matching strobe arrives within the window, bits 3..0 read 0 from the cycle after the window's last cycle. A later strobe does nothing.
- R7: A write that sets bit 0 and bit 3, with no other command bit, arms a 3-cycle window. A load strobe within it gives info_rd high for exactly one cycle, from the next cycle, with info_sel equal to Z-pointer bit 0. Bits 3 and 0 then read 0.
- R8: With more than one command bit set, no strobe starts any operation, and the window still expires.
- R9: A register write during an armed window restarts the window with the newly written bits.
- R10: Writing 1 to bit 4 while buf_filling is high gives buf_clear high for one cycle, in the cycle after the write. It is not given otherwise.
- R11: rdy_irq equals irq_en AND gie AND NOT sp_en AND NOT ee_busy AND NOT halt_cpu.
- R12: Register writes are ignored while a page operation is in progress.
- R13: A store strobe of the wrong kind does not start an operation, and neither does any strobe given while no window is armed. A strobe in the same cycle as a register write is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | CPU write strobe for the register |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Register read value |
| gie | input | 1 | Global interrupt flag of the CPU |
| st_strobe | input | 1 | Store-program instruction executing |
| ld_strobe | input | 1 | Load-program instruction executing |
| zptr | input | ZW (16) | Z-pointer value |
| buf_filling | input | 1 | Temporary page buffer is being filled |
| ee_busy | input | 1 | EEPROM write in progress |
| op_ack | input | 1 | Flash engine finished the requested page operation |
| write_req | output | 1 | Page write request |
| erase_req | output | 1 | Page erase request |
| page_addr | output | ZW-PAGE_LSB (10) | Page number for the request |
| halt_cpu | output | 1 | CPU halt during a page operation |
| buf_clear | output | 1 | One-cycle temporary buffer clear |
| info_rd | output | 1 | One-cycle lock/fuse read select pulse |
| info_sel | output | 1 | 0 selects lock bits, 1 selects fuse bits |
| rdy_irq | output | 1 | Ready interrupt request |

## Verification
The assertions rely on three properties of the environment. op_ack arrives only while a request is pending. No strobe of a new operation can start one while halt_cpu is high. Inputs change only between clock edges. The stimulus drives every input two time units after the rising edge. It raises op_ack both in directed sequences and at random cycles, and a design that is already idle ignores an acknowledge. The random phase weights register writes towards legal commands so that the windows open, expire and restart often.

// File: rtl/spm_ctl_pkg.sv
package spm_ctl_pkg;
   localparam int B_IE   = 7;
   localparam int B_SECT = 4;
   localparam int B_LOCK = 3;
   localparam int B_WR   = 2;
   localparam int B_ER   = 1;
   localparam int B_EN   = 0;
   localparam int REG_W  = 8;

   function automatic int max_int(int a, int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/spm_arm_timer.sv
module spm_arm_timer #(
   parameter int MAXV = 4,
   parameter int CW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          stop,
   output logic          active,
   output logic          last
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (load)           cnt <= load_val;
      else if (stop)           cnt <= '0;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);
   assign last   = (cnt == CW'(1));

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) <= MAXV);                                             // R6
   AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      active && !load && !stop |=> int'(cnt) == int'($past(cnt)) - 1); // R6
endmodule

// File: rtl/spm_op_tracker.sv
module spm_op_tracker #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          kind_wr,
   input  logic [AW-1:0] addr_in,
   input  logic          ack,
   output logic          busy,
   output logic          write_req,
   output logic          erase_req,
   output logic [AW-1:0] page_addr
);
   logic          kind_q;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         kind_q <= 1'b0;
         addr_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         kind_q <= kind_wr;
         addr_q <= addr_in;
      end else if (busy && ack) begin
         busy   <= 1'b0;
      end
   end

   assign write_req = busy &  kind_q;
   assign erase_req = busy & ~kind_q;
   assign page_addr = addr_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (write_req || erase_req) && !ack |=>
         write_req == $past(write_req) && erase_req == $past(erase_req)); // R5
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !ack |=> $stable(page_addr));                             // R3
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);                                                 // R12
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
   import spm_ctl_pkg::*;
#(
   parameter int ZW       = 16,
   parameter int PAGE_LSB = 6,
   parameter int WIN_PG   = 4,
   parameter int WIN_INFO = 3,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [REG_W-1:0]       reg_wdata,
   output logic [REG_W-1:0]       reg_rdata,
   input  logic                   gie,
   input  logic                   st_strobe,
   input  logic                   ld_strobe,
   input  logic [ZW-1:0]          zptr,
   input  logic                   buf_filling,
   input  logic                   ee_busy,
   input  logic                   op_ack,
   output logic                   write_req,
   output logic                   erase_req,
   output logic [ZW-PAGE_LSB-1:0] page_addr,
   output logic                   halt_cpu,
   output logic                   buf_clear,
   output logic                   info_rd,
   output logic                   info_sel,
   output logic                   rdy_irq
);
   localparam int AW   = ZW - PAGE_LSB;
   localparam int WMAX = max_int(WIN_PG, WIN_INFO);
   localparam int CW   = $clog2(WMAX + 1);

   if (WIN_PG < 1 || WIN_INFO < 1) begin : g_bad_win
      $error("selfprog_ctrl: windows must be at least one cycle");
   end
   if (PAGE_LSB < 2 || PAGE_LSB >= ZW) begin : g_bad_lsb
      $error("selfprog_ctrl: PAGE_LSB must lie in 2..ZW-1");
   end

   logic r_ie, r_sect, r_lock, r_wr, r_er, r_en;
   logic busy, win_active, win_last;
   logic wr_acc, single_cmd, pg_go, info_go, expire, done;
   logic [CW-1:0] win_len;
   logic irq_raw;
   logic unused_bits;

   assign unused_bits = ^{zptr[PAGE_LSB-1:1], reg_wdata[6:5]};

   assign wr_acc     = reg_we && !busy;
   assign single_cmd = ($countones({r_lock, r_wr, r_er}) == 1);
   assign pg_go      = win_active && !reg_we && st_strobe && single_cmd && (r_wr || r_er);
   assign info_go    = win_active && !reg_we && ld_strobe && single_cmd && r_lock;
   assign expire     = win_active && !reg_we && win_last && !pg_go && !info_go;
   assign done       = busy && op_ack;

   always_comb begin
      if (!reg_wdata[B_EN])
         win_len = '0;
      else if (reg_wdata[B_LOCK] && !reg_wdata[B_WR] && !reg_wdata[B_ER])
         win_len = CW'(WIN_INFO);
      else
         win_len = CW'(WIN_PG);
   end

   spm_arm_timer #(.MAXV(WMAX), .CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_acc),
      .load_val (win_len),
      .stop     (pg_go || info_go),
      .active   (win_active),
      .last     (win_last)
   );

   spm_op_tracker #(.AW(AW)) u_op (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (pg_go),
      .kind_wr   (r_wr),
      .addr_in   (zptr[ZW-1:PAGE_LSB]),
      .ack       (op_ack),
      .busy      (busy),
      .write_req (write_req),
      .erase_req (erase_req),
      .page_addr (page_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {r_ie, r_sect, r_lock, r_wr, r_er, r_en} <= '0;
      end else if (wr_acc) begin
         r_ie   <= reg_wdata[B_IE];
         r_sect <= reg_wdata[B_SECT];
         r_en   <= reg_wdata[B_EN];
         r_lock <= reg_wdata[B_LOCK] & reg_wdata[B_EN];
         r_wr   <= reg_wdata[B_WR]   & reg_wdata[B_EN];
         r_er   <= reg_wdata[B_ER]   & reg_wdata[B_EN];
      end else if (info_go || expire) begin
         {r_lock, r_wr, r_er, r_en} <= '0;
      end else if (done) begin
         {r_wr, r_er, r_en} <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_clear <= 1'b0;
         info_rd   <= 1'b0;
         info_sel  <= 1'b0;
      end else begin
         buf_clear <= wr_acc && reg_wdata[B_SECT] && buf_filling;
         info_rd   <= info_go;
         if (info_go) info_sel <= zptr[0];
      end
   end

   assign reg_rdata = {r_ie, 2'b00, r_sect, r_lock, r_wr, r_er, r_en};
   assign halt_cpu  = busy;
   assign irq_raw   = r_ie && gie && !r_en && !ee_busy && !busy;

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_raw;
      end
      assign rdy_irq = irq_q;
   end else begin : g_irq_comb
      assign rdy_irq = irq_raw;
      AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (ee_busy || halt_cpu) |-> !rdy_irq);                          // R11
   end

   AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_cpu) |-> $past(st_strobe) && !$past(reg_we));         // R13
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      halt_cpu && op_ack |=> !halt_cpu && !reg_rdata[B_EN]);           // R5
   AST_INFO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      info_rd |=> !info_rd);                                           // R7
   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({write_req, erase_req, info_rd}));                      // R8
endmodule

// File: tb/tb_selfprog_ctrl.sv
module tb_selfprog_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int ZW = 16;
   localparam int PLSB = 6;
   localparam int AW = ZW - PLSB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 0, gie = 0, st_strobe = 0, ld_strobe = 0;
   logic buf_filling = 0, ee_busy = 0, op_ack = 0;
   logic [7:0] reg_wdata = 0;
   logic [ZW-1:0] zptr = 0;
   logic [7:0] reg_rdata;
   logic write_req, erase_req, halt_cpu, buf_clear, info_rd, info_sel, rdy_irq;
   logic [AW-1:0] page_addr;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   selfprog_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .gie(gie), .st_strobe(st_strobe),
      .ld_strobe(ld_strobe), .zptr(zptr), .buf_filling(buf_filling),
      .ee_busy(ee_busy), .op_ack(op_ack), .write_req(write_req),
      .erase_req(erase_req), .page_addr(page_addr), .halt_cpu(halt_cpu),
      .buf_clear(buf_clear), .info_rd(info_rd), .info_sel(info_sel),
      .rdy_irq(rdy_irq)
   );

   // behavioural reference model
   bit m_ie, m_sect, m_lock, m_wr, m_er, m_en, m_busy, m_kw, m_bclr, m_info, m_isel;
   int m_cnt, m_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         {m_ie, m_sect, m_lock, m_wr, m_er, m_en, m_busy, m_kw, m_bclr, m_info, m_isel} = '0;
         m_cnt = 0; m_addr = 0;
      end else begin
         int ncmd;
         bit act, wa, pg, ig, ex, dn;
         ncmd = m_lock + m_wr + m_er;
         act = m_cnt > 0;
         wa  = reg_we && !m_busy;
         pg  = act && !reg_we && st_strobe && ncmd == 1 && (m_wr || m_er);
         ig  = act && !reg_we && ld_strobe && ncmd == 1 && m_lock;
         ex  = act && !reg_we && m_cnt == 1 && !pg && !ig;
         dn  = m_busy && op_ack;
         m_bclr = wa && reg_wdata[4] && buf_filling;
         m_info = ig;
         if (ig) m_isel = zptr[0];
         if (pg) begin m_busy = 1; m_kw = m_wr; m_addr = int'(zptr) / 64; end
         else if (dn) m_busy = 0;
         if (wa) m_cnt = !reg_wdata[0] ? 0 :
                         (reg_wdata[3] && !reg_wdata[2] && !reg_wdata[1]) ? 3 : 4;
         else if (pg || ig) m_cnt = 0;
         else if (act) m_cnt = m_cnt - 1;
         if (wa) begin
            m_ie = reg_wdata[7]; m_sect = reg_wdata[4]; m_en = reg_wdata[0];
            m_lock = reg_wdata[3] && reg_wdata[0];
            m_wr = reg_wdata[2] && reg_wdata[0];
            m_er = reg_wdata[1] && reg_wdata[0];
         end else if (ig || ex) begin
            m_en = 0; m_lock = 0; m_wr = 0; m_er = 0;
         end else if (dn) begin
            m_en = 0; m_wr = 0; m_er = 0;
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2 rdata", reg_rdata, {m_ie, 2'b00, m_sect, m_lock, m_wr, m_er, m_en});
         chk("R3 write_req", write_req, m_busy && m_kw);
         chk("R4 erase_req", erase_req, m_busy && !m_kw);
         chk("R5 halt_cpu", halt_cpu, m_busy);
         if (m_busy) chk("R3 page_addr", page_addr, m_addr);
         chk("R10 buf_clear", buf_clear, m_bclr);
         chk("R7 info_rd", info_rd, m_info);
         chk("R7 info_sel", info_sel, m_isel);
         chk("R11 rdy_irq", rdy_irq, m_ie && gie && !m_en && !ee_busy && !m_busy);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic step(int n = 1);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic wr(logic [7:0] v);
      reg_we = 1; reg_wdata = v; step(); reg_we = 0;
   endtask

   task automatic st(); st_strobe = 1; step(); st_strobe = 0; endtask
   task automatic ld(); ld_strobe = 1; step(); ld_strobe = 0; endtask
   task automatic ack(); op_ack = 1; step(); op_ack = 0; endtask

   initial begin
      step(3);
      rst_n = 1;
      // R1 reset state
      chk("R1 rdata", reg_rdata, 0);
      chk("R1 outputs", {write_req, erase_req, halt_cpu, buf_clear, info_rd, rdy_irq}, 0);
      // R2 readback and masked bits; command bits dropped without enable
      wr(8'hFE);
      chk("R2 readback", reg_rdata, 8'h90);
      wr(8'h00);
      // R3 page write, strobe in cycle 3
      zptr = 16'h1234;
      wr(8'h05); step(2); st();
      chk("R3 write_req", write_req, 1);
      chk("R3 page_addr", page_addr, 16'h1234 >> 6);
      // R12 writes ignored while busy
      wr(8'h80);
      chk("R12 ignored", reg_rdata, 8'h05);
      step(2);
      chk("R5 halt held", halt_cpu, 1);
      ack();
      chk("R5 released", {halt_cpu, write_req}, 0);
      chk("R5 bits clear", reg_rdata[2:0], 0);
      // R4 erase, strobe in cycle 1
      zptr = 16'hFFC0;
      wr(8'h03); st();
      chk("R4 erase_req", erase_req, 1);
      chk("R4 page_addr", page_addr, 10'h3FF);
      ack();
      // R3 boundary: strobe in cycle 4
      wr(8'h05); step(3); st();
      chk("R3 last cycle", write_req, 1);
      ack();
      // R6 expiry, then late strobe R13
      wr(8'h05); step(4);
      chk("R6 expired", reg_rdata, 0);
      st();
      chk("R13 late strobe", halt_cpu, 0);
      // R13 wrong strobe kind
      wr(8'h05); ld();
      chk("R13 wrong kind", {halt_cpu, info_rd}, 0);
      step(4);
      // R7 lock/fuse read in cycle 3
      zptr = 16'h0001;
      wr(8'h09); step(2); ld();
      chk("R7 info_rd", info_rd, 1);
      chk("R7 info_sel", info_sel, 1);
      chk("R7 bits clear", reg_rdata[3:0], 0);
      step();
      chk("R7 one pulse", info_rd, 0);
      // R7 window is 3 cycles: a load in cycle 4 is too late
      wr(8'h09); step(3); ld();
      chk("R7 too late", info_rd, 0);
      // R8 several command bits
      wr(8'h07); st();
      chk("R8 no op", halt_cpu, 0);
      step(3);
      chk("R8 expired", reg_rdata, 0);
      // R9 restart with new bits
      wr(8'h05); step(3); wr(8'h03); step(3); st();
      chk("R9 restart", erase_req, 1);
      ack();
      // R10 buffer clear
      buf_filling = 1; wr(8'h10);
      chk("R10 clear", buf_clear, 1);
      step();
      chk("R10 one pulse", buf_clear, 0);
      buf_filling = 0; wr(8'h10);
      chk("R10 not filling", buf_clear, 0);
      // R11 interrupt
      gie = 1; wr(8'h80);
      chk("R11 irq", rdy_irq, 1);
      ee_busy = 1; #1;
      chk("R11 eeprom quiet", rdy_irq, 0);
      ee_busy = 0; wr(8'h81);
      chk("R11 enable quiet", rdy_irq, 0);
      step(5);
      chk("R11 after expiry", rdy_irq, 1);
      // random phase, model compared every cycle
      for (int i = 0; i < 4000; i++) begin
         reg_we = ($urandom_range(0, 5) == 0);
         case ($urandom_range(0, 7))
            0: reg_wdata = 8'h05; 1: reg_wdata = 8'h03; 2: reg_wdata = 8'h09;
            3: reg_wdata = 8'h85; 4: reg_wdata = 8'h11;
            default: reg_wdata = 8'($urandom);
         endcase
         st_strobe = ($urandom_range(0, 3) == 0);
         ld_strobe = ($urandom_range(0, 3) == 0);
         op_ack = ($urandom_range(0, 2) == 0);
         gie = 1'($urandom); ee_busy = 1'($urandom); buf_filling = 1'($urandom);
         zptr = 16'($urandom);
         step();
      end
      {reg_we, st_strobe, ld_strobe, op_ack} = '0;
      step(2);
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule